// File: doc/BRIEF.md
# Trap Entry and Privilege Delegation Unit

This block performs trap entry for a small core with three privilege levels: user, supervisor and machine. When `trap_valid` is high for a cycle, the block uses the current privilege and two chained delegation masks, indexed by the exception code, to pick the handler level. On the next clock edge it loads that level's cause, exception-PC and trap-value registers. It also saves and clears the interrupt-enable bits of that level, records the privilege the trap came from and moves the current privilege to the handler level. One cycle after the request, it raises a single-cycle redirect whose address comes from the handler level's trap vector.

A small CSR port sets up the delegation masks, the three trap vectors, the status word and the current privilege, and lets software read every register back. Writes go through a registered port. Reads are combinational. Everything else about the CSR file lives elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: A trap targets machine level unless bit `trap_code` of the machine delegation mask is set and the current privilege is supervisor (2'b01) or user (2'b00). In that case it targets supervisor level. A trap taken at machine level (2'b11) is never delegated.
- R2: A trap from user level whose code bit is set in both the machine and the supervisor delegation masks targets user level. A trap with only the supervisor mask bit set targets machine level.
- R3: When the current privilege holds the unimplemented encoding 2'b10, the trap targets machine level and the machine previous-privilege field records 2'b10.
- R4: User-level entry copies the user interrupt enable (status bit 0) into user previous-enable (bit 4) and clears bit 0. The other status fields are unchanged.
- R5: Supervisor-level entry writes bit 0 of the source privilege into the supervisor previous-privilege bit (bit 8). It copies supervisor enable (bit 1) into supervisor previous-enable (bit 5) and clears bit 1.
- R6: Machine-level entry writes the source privilege into the machine previous-privilege field (bits 12:11). It copies machine enable (bit 3) into machine previous-enable (bit 7) and clears bit 3. Unlisted status bits always read zero.
- R7: The target level's cause register becomes the interrupt flag in bit XLEN-1 and the code in the low CODE_W bits, with all other bits zero.
- R8: The target level's exception-PC register takes `trap_pc` and its trap-value register takes `trap_tval`. The registers of the other two levels do not change.
- R9: In the cycle after a trap request, `cur_priv` equals the target level: user 2'b00, supervisor 2'b01, machine 2'b11.
- R10: `redirect_valid` is high in exactly the cycle after each trap request and low otherwise. `redirect_pc` is the target level's trap vector, as it stood before the trap edge, with bits 1:0 forced to zero.
- R11: CSR addresses are: 0 machine delegation, 1 supervisor delegation, 2/3/4 machine/supervisor/user vector, 5 status, 6 privilege, 8/9/10 machine cause/EPC/trap-value, 11/12/13 supervisor cause/EPC/trap-value, 14/15/7 user cause/EPC/trap-value. Addresses 7 to 15 are read-only. A status or privilege write in the same cycle as a trap is discarded, while a delegation or vector write in that cycle takes effect.
- R12: After synchronous reset, the privilege is machine (2'b11) and the status, delegation, vector, cause, EPC, trap-value and redirect outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request, one cycle per trap |
| trap_is_irq | input | 1 | Request is an interrupt |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| csr_we | input | 1 | CSR write enable |
| csr_waddr | input | 4 | CSR write address |
| csr_wdata | input | XLEN | CSR write data |
| csr_raddr | input | 4 | CSR read address |
| csr_rdata | output | XLEN | CSR read data, combinational |
| cur_priv | output | 2 | Current privilege level |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | XLEN | Handler address |

## Verification
Two things can fall on the same edge: a trap entry and a CSR write. The status and privilege writes collide with the trap's own updates. The vector and delegation writes collide with the values the trap reads. The bench arranges directed cases in which a trap and a write to the status word, to the privilege register, or to the target level's own vector arrive together. The random phase also lets writes ride along with traps. The bench judges the outcome against a model in which the trap update wins over status and privilege. In that model the redirect still uses the old vector, and the new vector shows up only on readback and on the next trap.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    localparam int NLVL  = 3;
    localparam int LVL_W = 2;
    localparam logic [LVL_W-1:0] LVL_U = 2'd0;
    localparam logic [LVL_W-1:0] LVL_S = 2'd1;
    localparam logic [LVL_W-1:0] LVL_M = 2'd2;

    typedef struct packed {
        priv_e mpp;
        logic  spp;
        logic  mpie;
        logic  spie;
        logic  upie;
        logic  mie;
        logic  sie;
        logic  uie;
    } status_t;

    localparam int STAT_BITS = 13;

    localparam logic [3:0] CA_MDELEG = 4'd0;
    localparam logic [3:0] CA_SDELEG = 4'd1;
    localparam logic [3:0] CA_MVEC   = 4'd2;
    localparam logic [3:0] CA_SVEC   = 4'd3;
    localparam logic [3:0] CA_UVEC   = 4'd4;
    localparam logic [3:0] CA_STATUS = 4'd5;
    localparam logic [3:0] CA_PRIV   = 4'd6;
    localparam logic [3:0] CA_UTVAL  = 4'd7;
    localparam logic [3:0] CA_MCAUSE = 4'd8;
    localparam logic [3:0] CA_MEPC   = 4'd9;
    localparam logic [3:0] CA_MTVAL  = 4'd10;
    localparam logic [3:0] CA_SCAUSE = 4'd11;
    localparam logic [3:0] CA_SEPC   = 4'd12;
    localparam logic [3:0] CA_STVAL  = 4'd13;
    localparam logic [3:0] CA_UCAUSE = 4'd14;
    localparam logic [3:0] CA_UEPC   = 4'd15;

    function automatic logic [LVL_W-1:0] priv_to_lvl(input priv_e p);
        case (p)
            PRIV_U:  return LVL_U;
            PRIV_S:  return LVL_S;
            default: return LVL_M;
        endcase
    endfunction

    function automatic logic [STAT_BITS-1:0] status_to_bits(input status_t s);
        return {s.mpp, 2'b00, s.spp, s.mpie, 1'b0, s.spie, s.upie,
                s.mie, 1'b0, s.sie, s.uie};
    endfunction

endpackage

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = $clog2(XLEN)
) (
    input  priv_e             from_priv,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   mdeleg,
    input  logic [XLEN-1:0]   sdeleg,
    output priv_e             target
);
    logic m_hit;
    logic s_hit;

    assign m_hit = mdeleg[code];
    assign s_hit = sdeleg[code];

    always_comb begin
        target = PRIV_M;
        if (m_hit && (from_priv == PRIV_S || from_priv == PRIV_U)) begin
            target = PRIV_S;
            if (from_priv == PRIV_U && s_hit) begin
                target = PRIV_U;
            end
        end
    end
endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
    import trap_pkg::*;
(
    input  status_t cur,
    input  priv_e   from_priv,
    input  priv_e   target,
    output status_t nxt
);
    always_comb begin
        nxt = cur;
        case (target)
            PRIV_U: begin
                nxt.upie = cur.uie;
                nxt.uie  = 1'b0;
            end
            PRIV_S: begin
                nxt.spp  = from_priv[0];
                nxt.spie = cur.sie;
                nxt.sie  = 1'b0;
            end
            default: begin
                nxt.mpp  = from_priv;
                nxt.mpie = cur.mie;
                nxt.mie  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] cause_in,
    input  logic [XLEN-1:0] epc_in,
    input  logic [XLEN-1:0] tval_in,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] tval_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            epc_q   <= '0;
            tval_q  <= '0;
        end else if (wr_en) begin
            cause_q <= cause_in;
            epc_q   <= epc_in;
            tval_q  <= tval_in;
        end
    end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_valid,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_tval,
    input  logic              csr_we,
    input  logic [3:0]        csr_waddr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [3:0]        csr_raddr,
    output logic [XLEN-1:0]   csr_rdata,
    output logic [1:0]        cur_priv,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    priv_e             priv_q;
    status_t           status_q;
    status_t           status_nxt;
    status_t           status_wr;
    priv_e             tgt;
    logic [LVL_W-1:0]  tgt_lvl;
    logic [XLEN-1:0]   mdeleg_q;
    logic [XLEN-1:0]   sdeleg_q;
    logic [XLEN-1:0]   vec_q   [NLVL];
    logic [XLEN-1:0]   cause_q [NLVL];
    logic [XLEN-1:0]   epc_q   [NLVL];
    logic [XLEN-1:0]   tval_q  [NLVL];
    logic [XLEN-1:0]   cause_word;

    trap_deleg_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_sel (
        .from_priv (priv_q),
        .code      (trap_code),
        .mdeleg    (mdeleg_q),
        .sdeleg    (sdeleg_q),
        .target    (tgt)
    );

    trap_status_upd u_stat (
        .cur       (status_q),
        .from_priv (priv_q),
        .target    (tgt),
        .nxt       (status_nxt)
    );

    assign tgt_lvl    = priv_to_lvl(tgt);
    assign cause_word = {trap_is_irq, {PAD_W{1'b0}}, trap_code};

    assign status_wr.mpp  = priv_e'(csr_wdata[12:11]);
    assign status_wr.spp  = csr_wdata[8];
    assign status_wr.mpie = csr_wdata[7];
    assign status_wr.spie = csr_wdata[5];
    assign status_wr.upie = csr_wdata[4];
    assign status_wr.mie  = csr_wdata[3];
    assign status_wr.sie  = csr_wdata[1];
    assign status_wr.uie  = csr_wdata[0];

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        trap_level_regs #(.XLEN(XLEN)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (trap_valid && (tgt_lvl == LVL_W'(g))),
            .cause_in (cause_word),
            .epc_in   (trap_pc),
            .tval_in  (trap_tval),
            .cause_q  (cause_q[g]),
            .epc_q    (epc_q[g]),
            .tval_q   (tval_q[g])
        );
    end

    // Trap entry owns priv/status on its edge; config registers are independent.
    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q         <= PRIV_M;
            status_q       <= '0;
            mdeleg_q       <= '0;
            sdeleg_q       <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            for (int i = 0; i < NLVL; i++) vec_q[i] <= '0;
        end else begin
            redirect_valid <= trap_valid;
            if (trap_valid) begin
                redirect_pc <= {vec_q[tgt_lvl][XLEN-1:2], 2'b00};
                priv_q      <= tgt;
                status_q    <= status_nxt;
            end else if (csr_we) begin
                if (csr_waddr == CA_STATUS) status_q <= status_wr;
                if (csr_waddr == CA_PRIV)   priv_q   <= priv_e'(csr_wdata[1:0]);
            end
            if (csr_we) begin
                case (csr_waddr)
                    CA_MDELEG: mdeleg_q     <= csr_wdata;
                    CA_SDELEG: sdeleg_q     <= csr_wdata;
                    CA_MVEC:   vec_q[LVL_M] <= csr_wdata;
                    CA_SVEC:   vec_q[LVL_S] <= csr_wdata;
                    CA_UVEC:   vec_q[LVL_U] <= csr_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (csr_raddr)
            CA_MDELEG: csr_rdata = mdeleg_q;
            CA_SDELEG: csr_rdata = sdeleg_q;
            CA_MVEC:   csr_rdata = vec_q[LVL_M];
            CA_SVEC:   csr_rdata = vec_q[LVL_S];
            CA_UVEC:   csr_rdata = vec_q[LVL_U];
            CA_STATUS: csr_rdata = {{(XLEN-STAT_BITS){1'b0}}, status_to_bits(status_q)};
            CA_PRIV:   csr_rdata = {{(XLEN-2){1'b0}}, priv_q};
            CA_UTVAL:  csr_rdata = tval_q[LVL_U];
            CA_MCAUSE: csr_rdata = cause_q[LVL_M];
            CA_MEPC:   csr_rdata = epc_q[LVL_M];
            CA_MTVAL:  csr_rdata = tval_q[LVL_M];
            CA_SCAUSE: csr_rdata = cause_q[LVL_S];
            CA_SEPC:   csr_rdata = epc_q[LVL_S];
            CA_STVAL:  csr_rdata = tval_q[LVL_S];
            CA_UCAUSE: csr_rdata = cause_q[LVL_U];
            default:   csr_rdata = epc_q[LVL_U];
        endcase
    end

    assign cur_priv = priv_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = $clog2(XLEN)
) (
    input logic              clk,
    input logic              rst,
    input logic              trap_valid,
    input logic [CODE_W-1:0] trap_code,
    input logic [1:0]        cur_priv,
    input logic              redirect_valid,
    input logic [XLEN-1:0]   redirect_pc,
    input logic              csr_we,
    input logic [3:0]        csr_waddr,
    input logic [XLEN-1:0]   mdeleg_q,
    input logic [XLEN-1:0]   sdeleg_q,
    input status_t           status_q
);
    assert_default_machine_R1: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && !mdeleg_q[trap_code]) |=> (cur_priv == PRIV_M));

    assert_no_deleg_from_m_R1: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && cur_priv == PRIV_M) |=> (cur_priv == PRIV_M));

    assert_user_target_R2: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && cur_priv == PRIV_U && mdeleg_q[trap_code] && sdeleg_q[trap_code])
        |=> (cur_priv == PRIV_U));

    assert_reserved_to_m_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && cur_priv == PRIV_RSV) |=> (cur_priv == PRIV_M && status_q.mpp == PRIV_RSV));

    assert_user_status_R4: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && cur_priv == PRIV_U && mdeleg_q[trap_code] && sdeleg_q[trap_code])
        |=> (!status_q.uie && status_q.upie == $past(status_q.uie)));

    assert_mach_status_R6: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && cur_priv == PRIV_M)
        |=> (!status_q.mie && status_q.mpie == $past(status_q.mie) && status_q.mpp == PRIV_M));

    assert_redirect_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> redirect_valid);

    assert_redirect_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |=> !redirect_valid);

    assert_redirect_align_R10: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_pc[1:0] == 2'b00));

    assert_priv_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!trap_valid && !(csr_we && csr_waddr == CA_PRIV)) |=> $stable(cur_priv));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .trap_valid     (trap_valid),
    .trap_code      (trap_code),
    .cur_priv       (cur_priv),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .csr_we         (csr_we),
    .csr_waddr      (csr_waddr),
    .mdeleg_q       (mdeleg_q),
    .sdeleg_q       (sdeleg_q),
    .status_q       (status_q)
);

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;
    localparam int XLEN   = 32;
    localparam int CODE_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              trap_valid = 1'b0;
    logic              trap_is_irq = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0]   trap_pc = '0;
    logic [XLEN-1:0]   trap_tval = '0;
    logic              csr_we = 1'b0;
    logic [3:0]        csr_waddr = '0;
    logic [XLEN-1:0]   csr_wdata = '0;
    logic [3:0]        csr_raddr = '0;
    logic [XLEN-1:0]   csr_rdata;
    logic [1:0]        cur_priv;
    logic              redirect_valid;
    logic [XLEN-1:0]   redirect_pc;

    int n_chk = 0;
    int n_bad = 0;

    // model state, level index 0 user, 1 supervisor, 2 machine
    logic [XLEN-1:0] m_mdeleg, m_sdeleg;
    logic [XLEN-1:0] m_vec [3];
    logic [XLEN-1:0] m_cause [3];
    logic [XLEN-1:0] m_epc [3];
    logic [XLEN-1:0] m_tval [3];
    logic [XLEN-1:0] m_status;
    logic [1:0]      m_priv;

    localparam logic [XLEN-1:0] STAT_MASK = 32'h0000_19BB;

    always #4 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (
        .clk, .rst, .trap_valid, .trap_is_irq, .trap_code, .trap_pc, .trap_tval,
        .csr_we, .csr_waddr, .csr_wdata, .csr_raddr, .csr_rdata,
        .cur_priv, .redirect_valid, .redirect_pc
    );

    task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int lvl_of(input logic [1:0] p);
        return (p == 2'b00) ? 0 : (p == 2'b01) ? 1 : 2;
    endfunction
    function automatic logic [3:0] cause_addr(input int l);
        return (l == 0) ? 4'd14 : (l == 1) ? 4'd11 : 4'd8;
    endfunction
    function automatic logic [3:0] epc_addr(input int l);
        return (l == 0) ? 4'd15 : (l == 1) ? 4'd12 : 4'd9;
    endfunction
    function automatic logic [3:0] tval_addr(input int l);
        return (l == 0) ? 4'd7 : (l == 1) ? 4'd13 : 4'd10;
    endfunction

    function automatic logic [1:0] exp_target(input logic [1:0] from, input logic [CODE_W-1:0] c);
        logic [1:0] t;
        t = 2'b11;
        if (m_mdeleg[c] && (from == 2'b00 || from == 2'b01)) t = 2'b01;
        if (t == 2'b01 && from == 2'b00 && m_sdeleg[c]) t = 2'b00;
        return t;
    endfunction

    task automatic rd(input logic [3:0] a, output logic [XLEN-1:0] d);
        csr_raddr = a;
        #1;
        d = csr_rdata;
    endtask

    // model of a CSR write; same_trap discards status/priv writes
    task automatic model_write(input logic [3:0] a, input logic [XLEN-1:0] d, input bit same_trap);
        case (a)
            4'd0: m_mdeleg = d;
            4'd1: m_sdeleg = d;
            4'd2: m_vec[2] = d;
            4'd3: m_vec[1] = d;
            4'd4: m_vec[0] = d;
            4'd5: if (!same_trap) m_status = d & STAT_MASK;
            4'd6: if (!same_trap) m_priv = d[1:0];
            default: ;
        endcase
    endtask

    task automatic csr_write(input logic [3:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_waddr = a; csr_wdata = d;
        model_write(a, d, 1'b0);
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic do_trap(input logic irq, input logic [CODE_W-1:0] c,
                           input logic [XLEN-1:0] pc, input logic [XLEN-1:0] tv,
                           input bit wr, input logic [3:0] wa, input logic [XLEN-1:0] wd);
        logic [1:0] from, tgt;
        int l, other;
        logic [XLEN-1:0] exp_pc, d, other_epc;
        @(negedge clk);
        trap_valid = 1'b1; trap_is_irq = irq; trap_code = c; trap_pc = pc; trap_tval = tv;
        csr_we = wr; csr_waddr = wa; csr_wdata = wd;
        from = m_priv;
        tgt = exp_target(from, c);
        l = lvl_of(tgt);
        other = (l + 1) % 3;
        other_epc = m_epc[other];
        exp_pc = {m_vec[l][XLEN-1:2], 2'b00};
        case (l)
            0: begin m_status[4] = m_status[0]; m_status[0] = 1'b0; end
            1: begin m_status[8] = from[0]; m_status[5] = m_status[1]; m_status[1] = 1'b0; end
            default: begin m_status[12:11] = from; m_status[7] = m_status[3]; m_status[3] = 1'b0; end
        endcase
        m_priv = tgt;
        m_cause[l] = {irq, {(XLEN-1-CODE_W){1'b0}}, c};
        m_epc[l] = pc;
        m_tval[l] = tv;
        if (wr) model_write(wa, wd, 1'b1);
        @(negedge clk);
        trap_valid = 1'b0; csr_we = 1'b0;
        check("R10 redirect_valid", {31'b0, redirect_valid}, 32'd1);
        check("R10 redirect_pc", redirect_pc, exp_pc);
        check("R9 R1 R2 R3 cur_priv", {30'b0, cur_priv}, {30'b0, tgt});
        rd(4'd5, d);
        check("R4 R5 R6 R11 status", d, m_status);
        rd(cause_addr(l), d);
        check("R7 cause", d, m_cause[l]);
        rd(epc_addr(l), d);
        check("R8 epc", d, pc);
        rd(tval_addr(l), d);
        check("R8 tval", d, tv);
        rd(epc_addr(other), d);
        check("R8 other level epc", d, other_epc);
        @(negedge clk);
        check("R10 redirect single pulse", {31'b0, redirect_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] d;
        void'($urandom(32'h5EED_1234));
        m_mdeleg = '0; m_sdeleg = '0; m_status = '0; m_priv = 2'b11;
        for (int i = 0; i < 3; i++) begin
            m_vec[i] = '0; m_cause[i] = '0; m_epc[i] = '0; m_tval[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 priv", {30'b0, cur_priv}, 32'd3);
        check("R12 redirect_valid", {31'b0, redirect_valid}, 32'd0);
        check("R12 redirect_pc", redirect_pc, 32'd0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R12 csr zero", d, (a == 6) ? 32'd3 : 32'd0);
        end

        // R11 setup and read-only addresses
        csr_write(4'd2, 32'h0000_1003);
        csr_write(4'd3, 32'h0000_2002);
        csr_write(4'd4, 32'h0000_3001);
        csr_write(4'd8, 32'hDEAD_BEEF);
        rd(4'd8, d);
        check("R11 cause read-only", d, 32'd0);
        rd(4'd3, d);
        check("R11 vector readback", d, 32'h0000_2002);

        // R1 from machine never delegated, R6 status
        csr_write(4'd0, 32'hFFFF_FFFF);
        csr_write(4'd5, 32'h0000_000B);
        do_trap(1'b0, 5'd2, 32'h100, 32'h11, 1'b0, 4'd0, '0);
        // R1 from supervisor with machine bit -> supervisor, R5
        csr_write(4'd6, 32'd1);
        csr_write(4'd5, 32'h0000_0003);
        do_trap(1'b1, 5'd7, 32'h204, 32'h22, 1'b0, 4'd0, '0);
        // R2 user with both bits -> user, R4
        csr_write(4'd1, 32'h0000_0100);
        csr_write(4'd6, 32'd0);
        csr_write(4'd5, 32'h0000_0001);
        do_trap(1'b0, 5'd8, 32'h308, 32'h33, 1'b0, 4'd0, '0);
        // R2 user with only supervisor bit -> machine
        csr_write(4'd0, 32'h0000_0000);
        csr_write(4'd6, 32'd0);
        do_trap(1'b0, 5'd8, 32'h40C, 32'h44, 1'b0, 4'd0, '0);
        // R1 user with only machine bit -> supervisor, spp gets 0
        csr_write(4'd0, 32'h0000_0010);
        csr_write(4'd1, 32'h0);
        csr_write(4'd6, 32'd0);
        do_trap(1'b1, 5'd4, 32'h510, 32'h55, 1'b0, 4'd0, '0);
        // R3 reserved privilege
        csr_write(4'd0, 32'hFFFF_FFFF);
        csr_write(4'd6, 32'd2);
        do_trap(1'b0, 5'd3, 32'h614, 32'h66, 1'b0, 4'd0, '0);
        // R11 same-cycle status write discarded
        csr_write(4'd5, 32'h0000_0008);
        do_trap(1'b0, 5'd1, 32'h718, 32'h77, 1'b1, 4'd5, 32'h0000_19BB);
        // R11 same-cycle priv write discarded
        do_trap(1'b0, 5'd1, 32'h71C, 32'h78, 1'b1, 4'd6, 32'd0);
        // R10 R11 same-cycle write to target vector: old used, new next time
        do_trap(1'b0, 5'd9, 32'h820, 32'h88, 1'b1, 4'd2, 32'hABCD_0007);
        rd(4'd2, d);
        check("R11 vector write beside trap", d, 32'hABCD_0007);
        do_trap(1'b1, 5'd31, 32'h824, 32'h89, 1'b0, 4'd0, '0);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int k;
            k = int'($urandom_range(0, 9));
            if (k < 4) begin
                logic [3:0] a;
                a = 4'($urandom_range(0, 6));
                csr_write(a, (a == 4'd6) ? 32'($urandom_range(0, 3)) : $urandom);
            end else begin
                bit wr;
                wr = ($urandom_range(0, 3) == 0);
                do_trap(1'($urandom), 5'($urandom), $urandom, $urandom,
                        wr, 4'($urandom_range(0, 15)), $urandom);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule